// File: doc/BRIEF.md
# DMA Request Descriptor Sequencer

This block takes one decoded DMA request descriptor and carries it through a fixed series of phases. A descriptor may ask for a synchronisation wait before the data moves, a transfer through an external data mover, a synchronisation wait after the transfer, and a doorbell write. The block then emits a response element when one is requested or an error was found, and it can raise a one-cycle interrupt pulse. The semaphore arithmetic, the data mover and linked-list walking are outside the block. The block only sequences them, decodes the packed command and doorbell attribute bytes, and rejects malformed descriptors.

Descriptors enter on a valid/ready stream and are taken only while the sequencer is idle. A source that holds `desc_valid` high simply waits. The doorbell write and the response leave on valid/ready streams. Once valid is raised, the payload stays fixed until ready is seen high at a clock edge. A low ready stalls the sequence in that phase for as long as it stays low. The synchronisation unit and the mover use plain level handshakes.

Top module: `dma_req_seq`

## Requirements
- R1: `desc_ready` is high only when no request is in flight. A descriptor is taken at a clock edge where `desc_valid` and `desc_ready` are both high, and `desc_ready` falls in the next cycle. While `desc_ready` is low, the request it would start has no effect on any output.
- R2: Command byte decode: bits 1:0 give the transfer kind (0 none, 1 toward the device, 2 from the device, 3 illegal), bit 3 selects bulk (1) or linked list (0), bit 4 requests a response, and bit 7 forces the completion interrupt. Bits 6, 5 and 2 have no effect on any output.
- R3: The observable events of one request occur strictly in this order: presync handshake, transfer start, postsync handshake, doorbell write, response, interrupt pulse. Each event appears only when enabled.
- R4: When the descriptor's presync (or postsync) flag is set, `sync_req` is raised with `sync_phase` 0 (or 1) and held until a clock edge with `sync_ok` high. A clear flag skips that wait.
- R5: For kind 1 or 2, `xfer_start` pulses for exactly one cycle, carrying the kind on `xfer_dir`, the bulk bit, the source address, the destination address and the full 32-bit length. The sequencer then waits for `xfer_done`. For kind 0 no start is issued.
- R6: Doorbell attribute bit 7 enables the write, and bits 1:0 select its width (0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 reserved). `bell_addr` is the doorbell address with bits 1:0 cleared. For 32-bit, `bell_be` is 1111 and the data passes unchanged. For 16-bit, `bell_be` is 0011 when address bit 1 is 0 and 1100 when it is 1, with data bits 15:0 in both halves. For 8-bit, `bell_be` has only bit `addr[1:0]` set, with data bits 7:0 in all four bytes.
- R7: On the doorbell and response streams, a valid that is not yet accepted stays high with an unchanged payload.
- R8: The response carries the descriptor's request ID and completion code 0 on success. It is emitted when command bit 4 is set or an error was found.
- R9: Error codes: 1 for an illegal transfer kind, 2 for a reserved doorbell width, and 3 for a doorbell address not aligned to its width. When several apply, the lowest code wins. An errored request performs no sync wait, transfer or doorbell write, and goes straight to the response.
- R10: With the doorbell disabled, its width and address fields are not checked and cause no error.
- R11: `done_irq` pulses for one cycle at the end of every request whose command bit 7 is set, after its response if it has one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Sequencer idle, descriptor can be taken |
| desc_id | input | ID_W | Request ID |
| desc_cmd | input | 8 | Packed command byte |
| desc_src | input | ADDR_W | Transfer source / list address |
| desc_dst | input | ADDR_W | Transfer destination |
| desc_len | input | LEN_W | Transfer length in bytes |
| desc_presync | input | 1 | Wait for sync before transfer |
| desc_postsync | input | 1 | Wait for sync after transfer |
| desc_bell_addr | input | ADDR_W | Doorbell byte address |
| desc_bell_attr | input | 8 | Packed doorbell attribute byte |
| desc_bell_data | input | 32 | Doorbell data |
| sync_req | output | 1 | Sync condition requested |
| sync_phase | output | 1 | 0 presync, 1 postsync |
| sync_ok | input | 1 | Sync condition satisfied |
| xfer_start | output | 1 | One-cycle transfer start |
| xfer_dir | output | 2 | Transfer kind (1 to device, 2 from device) |
| xfer_bulk | output | 1 | 1 bulk, 0 linked list |
| xfer_src | output | ADDR_W | Source address |
| xfer_dst | output | ADDR_W | Destination address |
| xfer_len | output | LEN_W | Length |
| xfer_done | input | 1 | Mover finished |
| bell_valid | output | 1 | Doorbell write pending |
| bell_ready | input | 1 | Doorbell write accepted |
| bell_addr | output | ADDR_W | Word-aligned doorbell address |
| bell_data | output | 32 | Lane-placed doorbell data |
| bell_be | output | 4 | Byte enables |
| rsp_valid | output | 1 | Response pending |
| rsp_ready | input | 1 | Response accepted |
| rsp_id | output | ID_W | Request ID echoed |
| rsp_code | output | CODE_W | Completion code |
| done_irq | output | 1 | Forced completion interrupt pulse |

## Verification
A corrupted phase state shows up at once as an event out of order, or as a missing or extra event: a sync request, a transfer start, a doorbell write or a response in the wrong place. A wrong state also shows as a `desc_ready` that stays low forever. The scoreboard catches this on the first event of the affected request, because every event is checked against the ordered list predicted from that descriptor. A wrong decode of the command or attribute fields shows on the transfer start or doorbell beat of the same request, within a few cycles. The payloads are compared field by field, and each byte-lane placement is exercised at every address offset used.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam int BELL_W     = 32;
  localparam int BELL_LANES = BELL_W / 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_EVAL, ST_PRE, ST_XFER, ST_XWAIT,
    ST_POST, ST_BELL, ST_RSP, ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    XK_NONE = 2'd0, XK_TO_DEV = 2'd1, XK_FROM_DEV = 2'd2, XK_BAD = 2'd3
  } xfer_kind_t;

  typedef enum logic [1:0] {
    BW_32 = 2'd0, BW_16 = 2'd1, BW_8 = 2'd2, BW_RSVD = 2'd3
  } bell_width_t;

  typedef enum logic [1:0] {
    CC_OK = 2'd0, CC_BAD_KIND = 2'd1, CC_BAD_WIDTH = 2'd2, CC_MISALIGN = 2'd3
  } cmpl_t;
endpackage

// File: rtl/dreq_bell_fmt.sv
module dreq_bell_fmt
  import dreq_pkg::*;
(
  input  bell_width_t           width,
  input  logic [1:0]            addr_lo,
  input  logic [BELL_W-1:0]     data_in,
  output logic [BELL_LANES-1:0] be,
  output logic [BELL_W-1:0]     data_out,
  output logic                  width_rsvd,
  output logic                  misalign
);
  // Per-lane enable and byte selection
  for (genvar g = 0; g < BELL_LANES; g++) begin : g_lane
    localparam logic [1:0] LANE_IDX = 2'(g);
    always_comb begin
      unique case (width)
        BW_32: begin
          be[g]             = 1'b1;
          data_out[8*g +: 8] = data_in[8*g +: 8];
        end
        BW_16: begin
          be[g]             = (addr_lo[1] == LANE_IDX[1]);
          data_out[8*g +: 8] = data_in[8*(g%2) +: 8];
        end
        BW_8: begin
          be[g]             = (addr_lo == LANE_IDX);
          data_out[8*g +: 8] = data_in[7:0];
        end
        default: begin
          be[g]             = 1'b0;
          data_out[8*g +: 8] = 8'h00;
        end
      endcase
    end
  end

  always_comb begin
    width_rsvd = (width == BW_RSVD);
    unique case (width)
      BW_32:   misalign = |addr_lo;
      BW_16:   misalign = addr_lo[0];
      default: misalign = 1'b0;
    endcase
  end
endmodule

// File: rtl/dreq_decode.sv
module dreq_decode
  import dreq_pkg::*;
(
  input  logic [7:0]  cmd,
  input  logic [7:0]  attr,
  input  logic        width_rsvd,
  input  logic        misalign,
  output xfer_kind_t  kind,
  output logic        bulk,
  output logic        want_rsp,
  output logic        force_irq,
  output logic        bell_en,
  output bell_width_t bell_width,
  output cmpl_t       code
);
  logic cmd_unused;
  logic attr_unused;
  assign cmd_unused  = ^{cmd[6:5], cmd[2]};
  assign attr_unused = ^attr[6:2];

  always_comb begin
    kind       = xfer_kind_t'(cmd[1:0]);
    bulk       = cmd[3];
    want_rsp   = cmd[4];
    force_irq  = cmd[7];
    bell_en    = attr[7];
    bell_width = bell_width_t'(attr[1:0]);
    if (kind == XK_BAD)               code = CC_BAD_KIND;
    else if (bell_en && width_rsvd)   code = CC_BAD_WIDTH;
    else if (bell_en && misalign)     code = CC_MISALIGN;
    else                              code = CC_OK;
  end
endmodule

// File: rtl/dreq_fsm.sv
module dreq_fsm
  import dreq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic desc_valid,
  input  logic has_err,
  input  logic has_pre,
  input  logic has_post,
  input  logic has_xfer,
  input  logic bell_en,
  input  logic want_rsp,
  input  logic force_irq,
  input  logic sync_ok,
  input  logic xfer_done,
  input  logic bell_ready,
  input  logic rsp_ready,
  output logic desc_ready,
  output logic load,
  output logic sync_req,
  output logic sync_phase,
  output logic xfer_start,
  output logic bell_valid,
  output logic rsp_valid,
  output logic done_irq
);
  seq_state_t state, nxt;
  seq_state_t after_pre, after_xfer, after_post, after_bell;

  // Skip chain: each phase falls through to the next enabled one
  always_comb begin
    after_bell = (want_rsp || has_err) ? ST_RSP : ST_DONE;
    after_post = bell_en  ? ST_BELL : after_bell;
    after_xfer = has_post ? ST_POST : after_post;
    after_pre  = has_xfer ? ST_XFER : after_xfer;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (desc_valid) nxt = ST_EVAL;
      ST_EVAL:  nxt = has_err ? ST_RSP : (has_pre ? ST_PRE : after_pre);
      ST_PRE:   if (sync_ok) nxt = after_pre;
      ST_XFER:  nxt = ST_XWAIT;
      ST_XWAIT: if (xfer_done) nxt = after_xfer;
      ST_POST:  if (sync_ok) nxt = after_post;
      ST_BELL:  if (bell_ready) nxt = after_bell;
      ST_RSP:   if (rsp_ready) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign desc_ready = (state == ST_IDLE);
  assign load       = desc_ready && desc_valid;
  assign sync_req   = (state == ST_PRE) || (state == ST_POST);
  assign sync_phase = (state == ST_POST);
  assign xfer_start = (state == ST_XFER);
  assign bell_valid = (state == ST_BELL);
  assign rsp_valid  = (state == ST_RSP);
  assign done_irq   = (state == ST_DONE) && force_irq;
endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
  import dreq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int ID_W   = 16,
  parameter int CODE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  desc_valid,
  output logic                  desc_ready,
  input  logic [ID_W-1:0]       desc_id,
  input  logic [7:0]            desc_cmd,
  input  logic [ADDR_W-1:0]     desc_src,
  input  logic [ADDR_W-1:0]     desc_dst,
  input  logic [LEN_W-1:0]      desc_len,
  input  logic                  desc_presync,
  input  logic                  desc_postsync,
  input  logic [ADDR_W-1:0]     desc_bell_addr,
  input  logic [7:0]            desc_bell_attr,
  input  logic [BELL_W-1:0]     desc_bell_data,
  output logic                  sync_req,
  output logic                  sync_phase,
  input  logic                  sync_ok,
  output logic                  xfer_start,
  output logic [1:0]            xfer_dir,
  output logic                  xfer_bulk,
  output logic [ADDR_W-1:0]     xfer_src,
  output logic [ADDR_W-1:0]     xfer_dst,
  output logic [LEN_W-1:0]      xfer_len,
  input  logic                  xfer_done,
  output logic                  bell_valid,
  input  logic                  bell_ready,
  output logic [ADDR_W-1:0]     bell_addr,
  output logic [BELL_W-1:0]     bell_data,
  output logic [BELL_LANES-1:0] bell_be,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [ID_W-1:0]       rsp_id,
  output logic [CODE_W-1:0]     rsp_code,
  output logic                  done_irq
);
  logic                r_pre, r_post;
  logic [ID_W-1:0]     r_id;
  logic [7:0]          r_cmd, r_attr;
  logic [ADDR_W-1:0]   r_src, r_dst, r_baddr;
  logic [LEN_W-1:0]    r_len;
  logic [BELL_W-1:0]   r_bdata;
  logic                load;

  xfer_kind_t  kind;
  bell_width_t bwidth;
  cmpl_t       code;
  logic        bulk, want_rsp, force_irq, bell_en, width_rsvd, misalign;

  // Descriptor capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_id <= '0; r_cmd <= '0; r_attr <= '0; r_src <= '0; r_dst <= '0;
      r_len <= '0; r_baddr <= '0; r_bdata <= '0; r_pre <= 1'b0; r_post <= 1'b0;
    end else if (load) begin
      r_id    <= desc_id;
      r_cmd   <= desc_cmd;
      r_attr  <= desc_bell_attr;
      r_src   <= desc_src;
      r_dst   <= desc_dst;
      r_len   <= desc_len;
      r_baddr <= desc_bell_addr;
      r_bdata <= desc_bell_data;
      r_pre   <= desc_presync;
      r_post  <= desc_postsync;
    end
  end

  dreq_decode u_decode (
    .cmd        (r_cmd),
    .attr       (r_attr),
    .width_rsvd (width_rsvd),
    .misalign   (misalign),
    .kind       (kind),
    .bulk       (bulk),
    .want_rsp   (want_rsp),
    .force_irq  (force_irq),
    .bell_en    (bell_en),
    .bell_width (bwidth),
    .code       (code)
  );

  dreq_bell_fmt u_bell (
    .width      (bwidth),
    .addr_lo    (r_baddr[1:0]),
    .data_in    (r_bdata),
    .be         (bell_be),
    .data_out   (bell_data),
    .width_rsvd (width_rsvd),
    .misalign   (misalign)
  );

  dreq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_valid (desc_valid),
    .has_err    (code != CC_OK),
    .has_pre    (r_pre),
    .has_post   (r_post),
    .has_xfer   (kind != XK_NONE),
    .bell_en    (bell_en),
    .want_rsp   (want_rsp),
    .force_irq  (force_irq),
    .sync_ok    (sync_ok),
    .xfer_done  (xfer_done),
    .bell_ready (bell_ready),
    .rsp_ready  (rsp_ready),
    .desc_ready (desc_ready),
    .load       (load),
    .sync_req   (sync_req),
    .sync_phase (sync_phase),
    .xfer_start (xfer_start),
    .bell_valid (bell_valid),
    .rsp_valid  (rsp_valid),
    .done_irq   (done_irq)
  );

  assign xfer_dir  = kind;
  assign xfer_bulk = bulk;
  assign xfer_src  = r_src;
  assign xfer_dst  = r_dst;
  assign xfer_len  = r_len;
  assign bell_addr = {r_baddr[ADDR_W-1:2], 2'b00};
  assign rsp_id    = r_id;
  assign rsp_code  = CODE_W'(code);
endmodule

// File: rtl/dma_req_seq_chk.sv
module dma_req_seq_chk #(
  parameter int ADDR_W = 64,
  parameter int ID_W   = 16,
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic              sync_req,
  input logic              sync_phase,
  input logic              sync_ok,
  input logic              xfer_start,
  input logic              bell_valid,
  input logic              bell_ready,
  input logic [ADDR_W-1:0] bell_addr,
  input logic [31:0]       bell_data,
  input logic [3:0]        bell_be,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ID_W-1:0]   rsp_id,
  input logic [CODE_W-1:0] rsp_code,
  input logic              done_irq
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> !(sync_req || xfer_start || bell_valid || rsp_valid || done_irq));

  assert_take_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready) |=> !desc_ready);

  assert_sync_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && !sync_ok) |=> (sync_req && $stable(sync_phase)));

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  assert_bell_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bell_valid |-> ($countones(bell_be) == 1 || $countones(bell_be) == 2 ||
                    $countones(bell_be) == 4));

  assert_bell_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bell_valid && !bell_ready) |=>
      (bell_valid && $stable(bell_addr) && $stable(bell_data) && $stable(bell_be)));

  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_id) && $stable(rsp_code)));

  assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> (!done_irq && desc_ready));
endmodule

bind dma_req_seq dma_req_seq_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .CODE_W(CODE_W)
) u_chk (.*);

// File: tb/dma_req_seq_bench.sv
`timescale 1ns/1ps
module dma_req_seq_bench;
  localparam int EV_PRE = 1, EV_XFER = 2, EV_POST = 3, EV_BELL = 4, EV_RSP = 5, EV_IRQ = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_valid = 1'b0, desc_ready;
  logic [15:0] desc_id = '0;
  logic [7:0]  desc_cmd = '0, desc_bell_attr = '0;
  logic [63:0] desc_src = '0, desc_dst = '0, desc_bell_addr = '0;
  logic [31:0] desc_len = '0, desc_bell_data = '0;
  logic        desc_presync = 1'b0, desc_postsync = 1'b0;
  logic        sync_req, sync_phase, sync_ok = 1'b0;
  logic        xfer_start, xfer_bulk, xfer_done = 1'b0;
  logic [1:0]  xfer_dir;
  logic [63:0] xfer_src, xfer_dst, bell_addr;
  logic [31:0] xfer_len, bell_data;
  logic        bell_valid, bell_ready = 1'b1;
  logic [3:0]  bell_be;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [15:0] rsp_id, rsp_code;
  logic        done_irq;

  always #2.5 clk = ~clk;

  dma_req_seq u_dma_req_seq (.*);

  typedef struct packed { logic [1:0] dir; logic bulk; logic [63:0] src; logic [63:0] dst; logic [31:0] len; } xexp_t;
  typedef struct packed { logic [63:0] addr; logic [31:0] data; logic [3:0] be; } bexp_t;
  typedef struct packed { logic [15:0] id; logic [15:0] code; } rexp_t;

  int    ev_q[$];
  xexp_t x_q[$];
  bexp_t b_q[$];
  rexp_t r_q[$];
  int    n_chk = 0, n_fail = 0;
  bit    bp_bell = 0, bp_rsp = 0;
  bit    finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic take_event(input int code);
    int e;
    if (ev_q.size() == 0) chk(1'b0, "R3", "unexpected event", code, 0);
    else begin
      e = ev_q.pop_front();
      chk(e == code, "R3", "phase order", code, e);
    end
  endtask

  // Monitor: samples between edges
  always @(negedge clk) if (rst_n) begin
    if (sync_req && sync_ok) take_event(sync_phase ? EV_POST : EV_PRE);
    if (xfer_start) begin
      take_event(EV_XFER);
      if (x_q.size() > 0) begin
        xexp_t e; e = x_q.pop_front();
        chk({xfer_dir, xfer_bulk, xfer_src, xfer_dst, xfer_len} == e, "R5", "transfer fields",
            {xfer_dir, xfer_bulk, xfer_src, xfer_dst, xfer_len}, e);
      end
    end
    if (bell_valid && bell_ready) begin
      take_event(EV_BELL);
      if (b_q.size() > 0) begin
        bexp_t e; e = b_q.pop_front();
        chk({bell_addr, bell_data, bell_be} == e, "R6", "doorbell beat",
            {bell_addr, bell_data, bell_be}, e);
      end
    end
    if (rsp_valid && rsp_ready) begin
      take_event(EV_RSP);
      if (r_q.size() > 0) begin
        rexp_t e; e = r_q.pop_front();
        chk({rsp_id, rsp_code} == e, "R8", "response", {rsp_id, rsp_code}, e);
      end
    end
    if (done_irq) take_event(EV_IRQ);
  end

  // Peripheral models: drive just after each rising edge
  int scnt = 0, xcnt = 0, bcnt = 0, rcnt = 0;
  always @(posedge clk) begin
    #1;
    if (sync_ok) begin sync_ok = 1'b0; scnt = 0; end
    else if (sync_req) begin
      scnt++;
      if (scnt >= 2) sync_ok = 1'b1;
    end
    if (xfer_done) xfer_done = 1'b0;
    else if (xfer_start) xcnt = 3;
    else if (xcnt > 0) begin
      xcnt--;
      if (xcnt == 0) xfer_done = 1'b1;
    end
    bcnt = bell_valid ? bcnt + 1 : 0;
    bell_ready = !bp_bell || (bcnt > 3);
    rcnt = rsp_valid ? rcnt + 1 : 0;
    rsp_ready = !bp_rsp || (rcnt > 2);
  end

  // Driver: predicts expected items from the requirements, then offers the descriptor
  task automatic send(input logic [15:0] id, input logic [7:0] cmd, input logic [63:0] src,
                      input logic [63:0] dst, input logic [31:0] len, input bit pre, input bit post,
                      input logic [63:0] baddr, input logic [7:0] battr, input logic [31:0] bdata);
    logic [1:0] ty;
    logic [1:0] w;
    bit         ben;
    int         code;
    bexp_t      be;
    ty = cmd[1:0]; w = battr[1:0]; ben = battr[7];
    code = 0;
    if (ty == 2'd3) code = 1;
    else if (ben && w == 2'd3) code = 2;
    else if (ben && ((w == 2'd0 && baddr[1:0] != 2'd0) || (w == 2'd1 && baddr[0]))) code = 3;
    if (code == 0) begin
      if (pre) ev_q.push_back(EV_PRE);
      if (ty != 2'd0) begin
        ev_q.push_back(EV_XFER);
        x_q.push_back({ty, cmd[3], src, dst, len});
      end
      if (post) ev_q.push_back(EV_POST);
      if (ben) begin
        be.addr = {baddr[63:2], 2'b00};
        case (w)
          2'd0: begin be.be = 4'hF; be.data = bdata; end
          2'd1: begin be.be = baddr[1] ? 4'hC : 4'h3; be.data = {2{bdata[15:0]}}; end
          default: begin be.be = 4'b0001 << baddr[1:0]; be.data = {4{bdata[7:0]}}; end
        endcase
        ev_q.push_back(EV_BELL);
        b_q.push_back(be);
      end
    end
    if (cmd[4] || code != 0) begin
      ev_q.push_back(EV_RSP);
      r_q.push_back({id, 16'(code)});
    end
    if (cmd[7]) ev_q.push_back(EV_IRQ);

    @(negedge clk);
    desc_id = id; desc_cmd = cmd; desc_src = src; desc_dst = dst; desc_len = len;
    desc_presync = pre; desc_postsync = post;
    desc_bell_addr = baddr; desc_bell_attr = battr; desc_bell_data = bdata;
    desc_valid = 1'b1;
    while (!desc_ready) @(negedge clk);
    @(negedge clk);
    desc_valid = 1'b0;
    chk(desc_ready == 1'b0, "R1", "ready low after take", desc_ready, 0);
  endtask

  task automatic drain();
    int guard = 0;
    while ((ev_q.size() != 0 || !desc_ready) && guard < 500) begin
      @(negedge clk); guard++;
    end
    chk(ev_q.size() == 0, "R3", "events outstanding", ev_q.size(), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({desc_ready, sync_req, xfer_start, bell_valid, rsp_valid, done_irq} == 6'b100000,
        "R1", "reset outputs", {desc_ready, sync_req, xfer_start, bell_valid, rsp_valid, done_irq}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R11: every phase, 32-bit doorbell, maximum length
    send(16'h0A01, 8'h99, 64'h1111_0000_0000_0040, 64'h2222_0000_0000_0080, 32'hFFFF_FFFF,
         1, 1, 64'h0000_0000_0000_1000, 8'h80, 32'hDEAD_BEEF);
    drain();
    // R6: 16-bit doorbell in upper half, no transfer, with response
    send(16'h0A02, 8'h10, 64'h0, 64'h0, 32'h0, 0, 0, 64'h0000_0000_0000_2006, 8'h81, 32'h1234_ABCD);
    drain();
    // R6 R7: 16-bit lower half with response back-pressure
    bp_rsp = 1;
    send(16'h0A03, 8'h10, 64'h0, 64'h0, 32'h0, 0, 1, 64'h0000_0000_0000_2004, 8'h81, 32'h0000_5566);
    drain();
    bp_rsp = 0;
    // R6 R7: 8-bit doorbells at each offset, from-device transfer, doorbell back-pressure
    bp_bell = 1;
    for (int k = 0; k < 4; k++)
      send(16'h0B00 + 16'(k), 8'h02, 64'h30 + 64'(k), 64'h40, 32'd64, 0, 0,
           64'h0000_0000_0000_3000 + 64'(k), 8'h82, 32'h0000_005A + 32'(k));
    drain();
    bp_bell = 0;
    // R9: illegal kind with presync and doorbell set -> code 1 only
    send(16'h0C01, 8'h13, 64'h1, 64'h2, 32'd8, 1, 1, 64'h0000_0000_0000_0002, 8'h83, 32'h1);
    drain();
    // R9: reserved width, no response bit -> code 2 response anyway
    send(16'h0C02, 8'h01, 64'h1, 64'h2, 32'd8, 1, 0, 64'h0000_0000_0000_0100, 8'h83, 32'h1);
    drain();
    // R9: misaligned 32-bit and 16-bit doorbells -> code 3
    send(16'h0C03, 8'h11, 64'h1, 64'h2, 32'd8, 0, 1, 64'h0000_0000_0000_4002, 8'h80, 32'h1);
    send(16'h0C04, 8'h00, 64'h1, 64'h2, 32'd8, 0, 0, 64'h0000_0000_0000_4001, 8'h81, 32'h1);
    drain();
    // R10: doorbell disabled, reserved width and odd address accepted
    send(16'h0D01, 8'h11, 64'h55, 64'h66, 32'd4, 0, 0, 64'h0000_0000_0000_0005, 8'h03, 32'h1);
    drain();
    // R2: reserved command bits set, linked-list to-device transfer, nothing else
    send(16'h0E01, 8'h65, 64'h77, 64'h88, 32'd12, 0, 0, 64'h0, 8'h7F, 32'h0);
    drain();
    // R11: forced interrupt with no response and no transfer
    send(16'h0F01, 8'h80, 64'h0, 64'h0, 32'h0, 0, 0, 64'h0, 8'h00, 32'h0);
    drain();
    // R1: back-to-back descriptors held valid while busy
    send(16'h1001, 8'h99, 64'h10, 64'h20, 32'd16, 1, 0, 64'h0000_0000_0000_0010, 8'h80, 32'hCAFE_F00D);
    send(16'h1002, 8'h1A, 64'h30, 64'h40, 32'd32, 0, 1, 64'h0, 8'h00, 32'h0);
    drain();
    repeat (5) @(negedge clk);
    chk(ev_q.size() == 0 && x_q.size() == 0 && b_q.size() == 0 && r_q.size() == 0,
        "R3", "scoreboard empty", ev_q.size() + x_q.size() + b_q.size() + r_q.size(), 0);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    summary();
  end
endmodule